// File: doc/BRIEF.md
# Asynchronous Serial Transceiver Core

This core sends and receives asynchronous serial characters on a single transmit pin and a single receive pin, with both directions running at the same time. A programmable divisor turns the system clock into a 16x oversampling tick. The same tick paces the transmitter and the receiver. A character carries 6, 7, 8 or 9 data bits, least significant bit first. An optional slot after the data bits holds either a parity bit or, in multi-drop mode, a flag that marks the character as an address.

The receiver takes a three-sample majority vote around the middle of each bit. It flags parity errors, framing errors and overrun, and it recognises a received line break. The transmitter can hold the line low to send a break. Three channel modes reroute the pins for testing: automatic echo, local loopback and remote loopback. Software-facing logic talks to the core through a write strobe with a ready flag for transmit, and a valid flag with a read strobe for receive.

Top module: `usart_core`

## Requirements
- R1: With divisor D (D = 0 behaves as 1), every transmitted bit, start bit included, lasts exactly 16*D clock cycles.
- R2: A frame is a low start bit, then `cfg_len`+6 data bits sent LSB first (`cfg_len` 0..3 gives 6..9 bits), then the optional slot bit, then one high stop bit. A received frame sets `rx_valid` and presents the data right-aligned in `rx_data`.
- R3: When `cfg_par_en`=1 and `cfg_multidrop`=0, the slot holds parity over the data bits. With `cfg_par_odd`=0 the slot bit makes the total count of ones even; with `cfg_par_odd`=1 it makes the count odd. On a received character whose slot disagrees, `rx_par_err`=1.
- R4: A received character whose stop bit is sampled low sets `rx_frm_err`=1, unless the character is a break.
- R5: If a character completes while `rx_valid` is still 1 and no read is made in that cycle, `rx_ovr` is set and `rx_data` takes the new character. Pulsing `rx_rd` clears `rx_valid` and `rx_ovr`.
- R6: While `tx_break`=1 and the transmitter has no character to send, `txd` is driven low. Once `tx_break` is released, `txd` returns high.
- R7: A received frame whose data bits, slot bit (if present) and stop bit are all low sets `rx_break`=1, `rx_frm_err`=0 and `rx_data`=0. The receiver then waits for the line to go high before it looks for a new start bit.
- R8: When `cfg_multidrop`=1 the slot is always present. The transmitter places `tx_addr` in it. The receiver copies the slot into `rx_addr` and never reports a parity error.
- R9: With `cfg_chmode`=2 (local loopback), `txd` stays high and the receiver is fed from the transmitter output.
- R10: With `cfg_chmode`=1 (automatic echo), `txd` equals `rxd` delayed by one clock, and the receiver still receives from `rxd`.
- R11: With `cfg_chmode`=3 (remote loopback), `txd` equals `rxd` delayed by one clock, and the receiver sees an idle line.
- R12: After reset, `txd`=1, `tx_ready`=1, `rx_valid`=0 and `rx_ovr`=0. `cfg_chmode`=0 is normal operation.
- R13: A transmission and a reception can run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Baud divisor; one oversampling tick every cfg_div clocks |
| cfg_len | input | 2 | Data bits minus six |
| cfg_par_en | input | 1 | Parity slot present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_multidrop | input | 1 | Slot carries the address flag |
| cfg_chmode | input | 2 | 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| tx_wr | input | 1 | Write strobe for a transmit character |
| tx_data | input | 9 | Transmit character |
| tx_addr | input | 1 | Address flag for multi-drop transmit |
| tx_break | input | 1 | Hold the line low when idle |
| tx_ready | output | 1 | Transmit holding register can accept a write |
| rx_rd | input | 1 | Read strobe; consumes the received character |
| rx_valid | output | 1 | A received character is waiting |
| rx_data | output | 9 | Received character, right-aligned |
| rx_par_err | output | 1 | Parity mismatch on the held character |
| rx_frm_err | output | 1 | Stop bit sampled low on the held character |
| rx_break | output | 1 | Held character is a line break |
| rx_addr | output | 1 | Held character carried the address flag |
| rx_ovr | output | 1 | A character was overwritten before it was read |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |

## Verification
A write leaves `txd` on the first baud tick after the write; `txd` then falls one clock after the internal line. Every later bit boundary therefore lands exactly 16*D clocks apart, and the bench's serial monitor samples each transmitted bit in its middle, half a bit after the falling start edge. A received character is decided at the middle of its stop bit, plus two synchroniser clocks and up to one tick. The bench checks the receive flags four clocks after it finishes driving the stop bit, and checks that a read clears them one clock later. In the echo and local loopback modes, the bench compares `txd` on every clock against `rxd` as sampled one edge earlier, or against a constant high.

// File: rtl/usart_pkg.sv
package usart_pkg;
  localparam int CHAR_W   = 9;
  localparam int MIN_BITS = 6;

  typedef logic [CHAR_W-1:0] char_t;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } ch_mode_e;

  function automatic logic [3:0] bits_of(input logic [1:0] len);
    return 4'(MIN_BITS) + {2'b00, len};
  endfunction

  function automatic char_t mask_of(input logic [3:0] nb);
    return ~({CHAR_W{1'b1}} << nb);
  endfunction
endpackage

// File: rtl/usart_baud.sv
module usart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = (div == '0) ? '0 : div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       md,
  input  logic       wr,
  input  char_t      wdata,
  input  logic       waddr,
  input  logic       brk_req,
  output logic       ready,
  output logic       line
);
  localparam int TCW = $clog2(OSR);
  localparam logic [TCW-1:0] T_END = TCW'(OSR - 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_SLOT, T_STOP, T_BRK} tst_e;

  tst_e           st;
  char_t          hold, sh, mask;
  logic           hold_addr, hold_full, slot_bit, slot_on, par_bit, bit_end;
  logic [3:0]     nb, bi;
  logic [TCW-1:0] tc;

  always_comb begin
    nb      = bits_of(len);
    mask    = mask_of(nb);
    slot_on = par_en | md;
    par_bit = (^(hold & mask)) ^ par_odd;
    bit_end = tick && (tc == T_END);
  end

  assign ready = ~hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      hold      <= '0;
      hold_addr <= 1'b0;
      hold_full <= 1'b0;
      sh        <= '0;
      slot_bit  <= 1'b0;
      bi        <= '0;
      tc        <= '0;
      line      <= 1'b1;
    end else begin
      if (wr && !hold_full) begin
        hold      <= wdata;
        hold_addr <= waddr;
        hold_full <= 1'b1;
      end
      if (tick) tc <= tc + 1'b1;
      case (st)
        T_IDLE: begin
          tc <= '0;
          if (hold_full && tick) begin
            sh        <= hold & mask;
            slot_bit  <= md ? hold_addr : par_bit;
            hold_full <= 1'b0;
            line      <= 1'b0;
            st        <= T_START;
          end else if (!hold_full && brk_req) begin
            line <= 1'b0;
            st   <= T_BRK;
          end
        end
        T_START: if (bit_end) begin
          line <= sh[0];
          bi   <= '0;
          st   <= T_DATA;
        end
        T_DATA: if (bit_end) begin
          if (bi == nb - 4'd1) begin
            if (slot_on) begin
              line <= slot_bit;
              st   <= T_SLOT;
            end else begin
              line <= 1'b1;
              st   <= T_STOP;
            end
          end else begin
            line <= sh[1];
            sh   <= sh >> 1;
            bi   <= bi + 4'd1;
          end
        end
        T_SLOT: if (bit_end) begin
          line <= 1'b1;
          st   <= T_STOP;
        end
        T_STOP: if (bit_end) st <= T_IDLE;
        T_BRK: begin
          tc <= '0;
          if (!brk_req) begin
            line <= 1'b1;
            st   <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd_in,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       md,
  input  logic       rd,
  output logic       valid,
  output char_t      data,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk,
  output logic       addr,
  output logic       ovr,
  output logic       done
);
  localparam int TCW = $clog2(OSR);
  localparam logic [TCW-1:0] T_S0  = TCW'(OSR / 2 - 1);
  localparam logic [TCW-1:0] T_S1  = TCW'(OSR / 2);
  localparam logic [TCW-1:0] T_DEC = TCW'(OSR / 2 + 1);
  localparam logic [TCW-1:0] T_END = TCW'(OSR - 1);

  typedef enum logic [2:0] {R_HUNT, R_START, R_DATA, R_SLOT, R_STOP, R_WAITHI} rst_e;

  rst_e           st;
  logic           s1, s2, vote, zero, slot_v, slot_on, is_brk, bad_par;
  logic [1:0]     smp;
  logic [3:0]     nb, bi;
  logic [TCW-1:0] tc;
  char_t          sh, aligned;

  always_comb begin
    nb      = bits_of(len);
    slot_on = par_en | md;
    vote    = (smp[1] & smp[0]) | (smp[1] & s2) | (smp[0] & s2);
    aligned = sh >> (4'(CHAR_W) - nb);
    is_brk  = zero && !vote && (!slot_on || !slot_v);
    bad_par = slot_on && !md && (slot_v != ((^aligned) ^ par_odd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      st      <= R_HUNT;
      tc      <= '0;
      bi      <= '0;
      sh      <= '0;
      smp     <= '0;
      zero    <= 1'b0;
      slot_v  <= 1'b0;
      valid   <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      brk     <= 1'b0;
      addr    <= 1'b0;
      ovr     <= 1'b0;
      done    <= 1'b0;
    end else begin
      s1   <= rxd_in;
      s2   <= s1;
      done <= 1'b0;
      if (rd) begin
        valid <= 1'b0;
        ovr   <= 1'b0;
      end
      case (st)
        R_HUNT: begin
          tc <= '0;
          if (tick && !s2) begin
            tc <= TCW'(1);
            st <= R_START;
          end
        end
        R_WAITHI: begin
          tc <= '0;
          if (s2) st <= R_HUNT;
        end
        default: if (tick) begin
          tc <= tc + 1'b1;
          if (tc == T_S0) smp[1] <= s2;
          if (tc == T_S1) smp[0] <= s2;
          if (tc == T_DEC) begin
            case (st)
              R_START: if (vote) st <= R_HUNT;
              R_DATA: begin
                sh   <= {vote, sh[CHAR_W-1:1]};
                zero <= zero & ~vote;
              end
              R_SLOT: slot_v <= vote;
              R_STOP: begin
                valid   <= 1'b1;
                done    <= 1'b1;
                data    <= is_brk ? '0 : aligned;
                brk     <= is_brk;
                frm_err <= !vote && !is_brk;
                par_err <= bad_par && !is_brk;
                addr    <= md && slot_v && !is_brk;
                if (valid && !rd) ovr <= 1'b1;
                st      <= vote ? R_HUNT : R_WAITHI;
              end
              default: ;
            endcase
          end
          if (tc == T_END) begin
            case (st)
              R_START: begin
                st   <= R_DATA;
                bi   <= '0;
                zero <= 1'b1;
              end
              R_DATA: begin
                if (bi == nb - 4'd1) st <= slot_on ? R_SLOT : R_STOP;
                else bi <= bi + 4'd1;
              end
              R_SLOT: st <= R_STOP;
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/usart_core.sv
module usart_core
  import usart_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_multidrop,
  input  logic [1:0]       cfg_chmode,
  input  logic             tx_wr,
  input  logic [8:0]       tx_data,
  input  logic             tx_addr,
  input  logic             tx_break,
  output logic             tx_ready,
  input  logic             rx_rd,
  output logic             rx_valid,
  output logic [8:0]       rx_data,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_break,
  output logic             rx_addr,
  output logic             rx_ovr,
  input  logic             rxd,
  output logic             txd
);
  logic     tick, tx_line, rx_src, rx_done;
  ch_mode_e mode;

  assign mode = ch_mode_e'(cfg_chmode);

  usart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(cfg_div), .tick(tick)
  );

  usart_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .len(cfg_len),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .md(cfg_multidrop),
    .wr(tx_wr), .wdata(tx_data), .waddr(tx_addr), .brk_req(tx_break),
    .ready(tx_ready), .line(tx_line)
  );

  always_comb begin
    case (mode)
      CH_LOCAL:  rx_src = tx_line;
      CH_REMOTE: rx_src = 1'b1;
      default:   rx_src = rxd;
    endcase
  end

  usart_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_in(rx_src), .len(cfg_len),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .md(cfg_multidrop),
    .rd(rx_rd), .valid(rx_valid), .data(rx_data), .par_err(rx_par_err),
    .frm_err(rx_frm_err), .brk(rx_break), .addr(rx_addr), .ovr(rx_ovr),
    .done(rx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else begin
      case (mode)
        CH_NORMAL: txd <= tx_line;
        CH_LOCAL:  txd <= 1'b1;
        default:   txd <= rxd;
      endcase
    end
  end
endmodule

// File: rtl/usart_sva.sv
module usart_sva (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_chmode,
  input logic       cfg_multidrop,
  input logic       rxd,
  input logic       txd,
  input logic       rx_rd,
  input logic       rx_valid,
  input logic [8:0] rx_data,
  input logic       rx_ovr,
  input logic       rx_par_err,
  input logic       rx_frm_err,
  input logic       rx_break,
  input logic       rx_done
);
  assert_local_high_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_chmode == 2'd2 && $past(cfg_chmode) == 2'd2 && !$past(rst)) |-> txd);

  assert_echo_copy_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_chmode == 2'd1 && $past(cfg_chmode) == 2'd1 && !$past(rst)) |-> (txd == $past(rxd)));

  assert_remote_copy_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_chmode == 2'd3 && $past(cfg_chmode) == 2'd3 && !$past(rst)) |-> (txd == $past(rxd)));

  assert_ovr_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr) |-> ($past(rx_valid) && rx_valid));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> ((!rx_valid || rx_done) && !rx_ovr));

  assert_break_clean_R7: assert property (@(posedge clk) disable iff (rst)
    rx_break |-> (!rx_frm_err && rx_data == 9'd0));

  assert_md_no_parerr_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && cfg_multidrop && $past(cfg_multidrop)) |-> !rx_par_err);

  assert_done_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> rx_valid);
endmodule

bind usart_core usart_sva u_sva (
  .clk(clk), .rst(rst), .cfg_chmode(cfg_chmode), .cfg_multidrop(cfg_multidrop),
  .rxd(rxd), .txd(txd), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_ovr(rx_ovr), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
  .rx_break(rx_break), .rx_done(rx_done)
);

// File: tb/tb_usart_core.sv
`timescale 1ns/1ps
module tb_usart_core;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] cfg_div = 16'd2;
  logic [1:0]  cfg_len = 2'd2;
  logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_multidrop = 1'b0;
  logic [1:0]  cfg_chmode = 2'd0;
  logic        tx_wr = 1'b0, tx_addr = 1'b0, tx_break = 1'b0, rx_rd = 1'b0, rxd = 1'b1;
  logic [8:0]  tx_data = '0;
  logic        tx_ready, rx_valid, rx_par_err, rx_frm_err, rx_break, rx_addr, rx_ovr, txd;
  logic [8:0]  rx_data;

  usart_core dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_multidrop(cfg_multidrop),
    .cfg_chmode(cfg_chmode), .tx_wr(tx_wr), .tx_data(tx_data), .tx_addr(tx_addr),
    .tx_break(tx_break), .tx_ready(tx_ready), .rx_rd(rx_rd), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_break(rx_break), .rx_addr(rx_addr), .rx_ovr(rx_ovr), .rxd(rxd), .txd(txd)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  bit mon_en = 1'b1, chk_copy = 1'b0, chk_local = 1'b0;
  logic rxd_q = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit par_of(input int d, input int nb, input bit odd);
    int c = 0;
    for (int i = 0; i < nb; i++) c += d[i];
    return bit'(c % 2) ^ odd;
  endfunction

  // per-clock model of the pin paths in the test modes
  always @(posedge clk) rxd_q <= rxd;
  always @(negedge clk) begin
    if (chk_copy)  chk(txd == rxd_q, "R10", "txd follows rxd", txd, rxd_q);
    if (chk_local) chk(txd == 1'b1, "R9", "txd held high", txd, 1);
  end

  // serial monitor on txd: samples each bit at its middle
  initial begin : tx_mon
    int bc, nbm, val, e;
    bit so, sb, stp;
    forever begin
      @(negedge clk);
      if (mon_en && txd === 1'b0) begin
        bc = 16 * int'(cfg_div); nbm = 6 + int'(cfg_len);
        so = cfg_par_en | cfg_multidrop; val = 0; sb = 0;
        repeat (bc / 2 - 1) @(negedge clk);
        chk(txd == 1'b0, "R1", "start bit at mid", txd, 0);
        for (int i = 0; i < nbm; i++) begin
          repeat (bc) @(negedge clk);
          val |= int'(txd) << i;
        end
        if (so) begin
          repeat (bc) @(negedge clk);
          sb = txd;
        end
        repeat (bc) @(negedge clk);
        stp = txd;
        chk(stp == 1'b1, "R2", "stop bit", stp, 1);
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected frame", val, -1);
        else begin
          e = exp_q.pop_front();
          chk(val == (e & 511), "R2", "tx data bits", val, e & 511);
          if (so) chk(sb == e[9], cfg_multidrop ? "R8" : "R3", "tx slot bit", sb, e[9]);
        end
      end
    end
  end

  task automatic tx_send(input int d, input bit ad, input bit expect_out);
    int nb = 6 + int'(cfg_len);
    int m = d & ((1 << nb) - 1);
    bit sl = cfg_multidrop ? ad : par_of(m, nb, cfg_par_odd);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_wr = 1'b1; tx_data = 9'(d); tx_addr = ad;
    if (expect_out) exp_q.push_back(m | (int'(sl) << 9));
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic tx_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (16 * int'(cfg_div)) @(negedge clk);
  endtask

  task automatic send_rx(input int d, input bit slot_on, input bit slotv, input bit stopv);
    int bc = 16 * int'(cfg_div);
    int nb = 6 + int'(cfg_len);
    rxd = 1'b0; repeat (bc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; repeat (bc) @(negedge clk);
    end
    if (slot_on) begin
      rxd = slotv; repeat (bc) @(negedge clk);
    end
    rxd = stopv; repeat (bc) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic rx_expect(input int d, input bit pe, input bit fe, input bit bk,
                           input bit ad, input bit ov, input string req);
    repeat (4) @(negedge clk);
    chk(rx_valid == 1'b1, req, "rx_valid", rx_valid, 1);
    chk(rx_data == 9'(d), req, "rx_data", rx_data, d);
    chk(rx_par_err == pe, req, "rx_par_err", rx_par_err, pe);
    chk(rx_frm_err == fe, req, "rx_frm_err", rx_frm_err, fe);
    chk(rx_break == bk, req, "rx_break", rx_break, bk);
    chk(rx_addr == ad, req, "rx_addr", rx_addr, ad);
    chk(rx_ovr == ov, req, "rx_ovr", rx_ovr, ov);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk(!rx_valid && !rx_ovr, "R5", "read clears valid and overrun", {rx_valid, rx_ovr}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R13 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && tx_ready == 1'b1, "R12", "reset txd/tx_ready", {txd, tx_ready}, 3);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R12", "txd idle after reset", txd, 1);
    chk(tx_ready == 1'b1, "R12", "tx_ready after reset", tx_ready, 1);
    chk(!rx_valid && !rx_ovr, "R12", "receive flags after reset", {rx_valid, rx_ovr}, 0);

    // 8 data bits, no parity, back-to-back writes
    tx_send(9'h0A5, 1'b0, 1'b1);
    tx_send(9'h03C, 1'b0, 1'b1);
    tx_drain();
    // R13 full duplex: transmit and receive together
    fork
      tx_send(9'h05A, 1'b0, 1'b1);
      send_rx(8'h96, 1'b0, 1'b0, 1'b1);
    join
    rx_expect(8'h96, 0, 0, 0, 0, 0, "R13");
    tx_drain();

    // 6 bits, even parity (R3)
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    tx_send(9'h02B, 1'b0, 1'b1);
    tx_drain();
    send_rx(6'h15, 1'b1, par_of(6'h15, 6, 1'b0), 1'b1);
    rx_expect(6'h15, 0, 0, 0, 0, 0, "R3");
    send_rx(6'h15, 1'b1, ~par_of(6'h15, 6, 1'b0), 1'b1);
    rx_expect(6'h15, 1, 0, 0, 0, 0, "R3");

    // 7 bits, odd parity (R3)
    cfg_len = 2'd1; cfg_par_odd = 1'b1;
    tx_send(9'h055, 1'b0, 1'b1);
    tx_drain();
    send_rx(7'h41, 1'b1, par_of(7'h41, 7, 1'b1), 1'b1);
    rx_expect(7'h41, 0, 0, 0, 0, 0, "R3");

    // 9 bits, no parity, divisor 3 (R1, R2)
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_div = 16'd3;
    repeat (8) @(negedge clk);
    tx_send(9'h1C3, 1'b0, 1'b1);
    tx_drain();
    send_rx(9'h12F, 1'b0, 1'b0, 1'b1);
    rx_expect(9'h12F, 0, 0, 0, 0, 0, "R2");

    // 8 bits, framing error (R4)
    cfg_len = 2'd2; cfg_div = 16'd2;
    repeat (8) @(negedge clk);
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    rx_expect(8'h81, 0, 1, 0, 0, 0, "R4");

    // overrun (R5)
    send_rx(8'h11, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b0, 1'b1);
    rx_expect(8'h22, 0, 0, 0, 0, 1, "R5");

    // transmit break (R6)
    mon_en = 1'b0;
    tx_break = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd == 1'b0, "R6", "txd low during break", txd, 0);
    repeat (200) @(negedge clk);
    chk(txd == 1'b0, "R6", "txd still low during break", txd, 0);
    tx_break = 1'b0;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1, "R6", "txd high after break", txd, 1);
    mon_en = 1'b1;

    // receive break, then a normal character (R7)
    rxd = 1'b0;
    repeat (16 * 2 * 12) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    rx_expect(0, 0, 0, 1, 0, 0, "R7");
    send_rx(8'h7E, 1'b0, 1'b0, 1'b1);
    rx_expect(8'h7E, 0, 0, 0, 0, 0, "R7");

    // multi-drop (R8)
    cfg_multidrop = 1'b1;
    tx_send(9'h042, 1'b1, 1'b1);
    tx_send(9'h043, 1'b0, 1'b1);
    tx_drain();
    send_rx(8'h09, 1'b1, 1'b1, 1'b1);
    rx_expect(8'h09, 0, 0, 0, 1, 0, "R8");
    cfg_par_en = 1'b1;
    send_rx(8'h03, 1'b1, 1'b1, 1'b1);
    rx_expect(8'h03, 0, 0, 0, 1, 0, "R8");
    send_rx(8'h03, 1'b1, 1'b0, 1'b1);
    rx_expect(8'h03, 0, 0, 0, 0, 0, "R8");
    cfg_multidrop = 1'b0; cfg_par_en = 1'b0;

    // local loopback (R9)
    mon_en = 1'b0;
    cfg_chmode = 2'd2;
    repeat (3) @(negedge clk);
    chk_local = 1'b1;
    tx_send(9'h06D, 1'b0, 1'b0);
    repeat (16 * 2 * 12) @(negedge clk);
    chk_local = 1'b0;
    rx_expect(8'h6D, 0, 0, 0, 0, 0, "R9");

    // automatic echo (R10)
    cfg_chmode = 2'd1;
    repeat (3) @(negedge clk);
    chk_copy = 1'b1;
    send_rx(8'h4B, 1'b0, 1'b0, 1'b1);
    rx_expect(8'h4B, 0, 0, 0, 0, 0, "R10");
    chk_copy = 1'b0;

    // remote loopback (R11)
    cfg_chmode = 2'd3;
    repeat (3) @(negedge clk);
    chk_copy = 1'b1;
    send_rx(8'h77, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(rx_valid == 1'b0, "R11", "receiver idle in remote loopback", rx_valid, 0);
    chk_copy = 1'b0;
    cfg_chmode = 2'd0;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all transmitted frames seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule